// File: doc/BRIEF.md
# Quadrature Encoder Counter with Locked Configuration

This peripheral follows one incremental encoder channel, given as a phase A and a phase B input. Both inputs pass through synchronisers. Every legal change of the phase pair is turned into an up or down event, so the decoder counts four events per encoder cycle. The events go through a power-of-two divider and then step a 16-bit counter. The counter runs between a software-set lower bound and a software-set upper bound and wraps at each end.

Software reaches the block through a flat word-addressed register port. A write takes effect on the clock edge that samples the strobe, and reads are combinational. The prescaler, mode and decoder-enable settings sit behind a lock that is set at reset. Software must open the lock before it configures the block and should close it again afterwards. The two bounds accept writes only while the mode enable bit is set. Any write to the count register loads the lower bound into the counter and ignores the data written.

Top module: `qdec_timer`

## Requirements
- R1: After reset the lock is set (address 5 reads 0x40), the count is 0, the lower bound is 0, the upper bound is 0xFFFF, and the mode, prescaler and decoder-enable registers read 0.
- R2: With the decoder enabled (address 6 bit 0 = 1) and prescale 0, each legal change of the pair {A,B} in the order 00, 10, 11, 01, 00 adds one to the count, and each change in the reverse order subtracts one.
- R3: A sample in which A and B both change leaves the count unchanged.
- R4: While the decoder enable bit is 0, phase changes do not alter the count.
- R5: A write of any data to the count register (address 1) loads the lower bound (address 3) into the counter and discards the written data.
- R6: Counting up from the upper bound (address 2) gives the lower bound, and counting down from the lower bound gives the upper bound.
- R7: The prescale field (address 0 bits 2:0) divides count events by 2^field: 2^field events in one direction move the count by one. Every accepted write to address 0 clears the divider remainder.
- R8: While locked, writes to address 0, to the enable bit of address 4 and to address 6 are ignored. Writing address 4 with bit 2 set opens the lock. Writing address 5 with bit 6 set closes it.
- R9: While the mode enable bit (address 4 bit 0) is 0, writes to the upper bound and the lower bound are ignored.
- R10: Address 7 reads zero, and the unlock bit (address 4 bit 2) always reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |

## Verification
The bench walks the pair through a full up sequence, then reverses it through zero. A design with the direction reversed or the wrap bound swapped reads back 0x0001 where 0xFFFF is expected. It then changes both phases at once. A decoder that guessed a direction would move the count. It sets narrow bounds to catch a wrap that goes to 0 instead of the lower bound, counts with prescale 2 after a mid-way rewrite of the prescaler, which shows up a divider that keeps its remainder, and writes while locked and while the mode enable bit is clear, so that a missing gate shows up in the register read-back.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned PS_W   = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_UPPER = 3'd2,
    A_LOWER = 3'd3,
    A_MODE  = 3'd4,
    A_STAT  = 3'd5,
    A_QCTRL = 3'd6
  } reg_addr_e;

  localparam int unsigned MODE_ENA_BIT  = 0;
  localparam int unsigned MODE_OPEN_BIT = 2;
  localparam int unsigned STAT_LOCK_BIT = 6;
  localparam int unsigned QCTRL_EN_BIT  = 0;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/qdec_phase.sv
module qdec_phase (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ab_i,
  output logic [1:0] prev_o,
  output logic       up_o,
  output logic       dn_o
);
  logic [1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b00;
    else         prev_q <= ab_i;
  end

  // A leads B: 00 -> 10 -> 11 -> 01 -> 00 counts up; double change matches neither
  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    unique case ({prev_q, ab_i})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: up_o = 1'b1;
      4'b1000, 4'b1110, 4'b0111, 4'b0001: dn_o = 1'b1;
      default: ;
    endcase
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/qdec_presc.sv
module qdec_presc #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            up_i,
  input  logic            dn_i,
  output logic            step_up_o,
  output logic            step_dn_o
);
  localparam int unsigned RES_W = (1 << PS_W) - 1;

  logic [RES_W-1:0] res_q, mask;

  assign mask      = ~({RES_W{1'b1}} << ps_i);
  assign step_up_o = up_i && ((res_q & mask) == mask);
  assign step_dn_o = dn_i && ((res_q & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         res_q <= '0;
    else if (clr_i)      res_q <= '0;
    else if (up_i)       res_q <= step_up_o ? '0 : res_q + 1'b1;
    else if (dn_i)       res_q <= step_dn_o ? mask : res_q - 1'b1;
  end
endmodule

// File: rtl/qdec_count.sv
module qdec_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] lower_i,
  input  logic [W-1:0] upper_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= lower_i;
    else if (inc_i)  cnt_q <= (cnt_q == upper_i) ? lower_i : cnt_q + 1'b1;
    else if (dec_i)  cnt_q <= (cnt_q == lower_i) ? upper_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/qdec_timer.sv
module qdec_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [qdec_pkg::REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic                       phase_a_i,
  input  logic                       phase_b_i
);
  import qdec_pkg::*;

  logic [PS_W-1:0]  ps_q;
  logic             ena_q, qen_q, lock_q;
  logic [CNT_W-1:0] lower_q, upper_q, cnt;
  logic [1:0]       ab_s, ab_p;
  logic             ev_up, ev_dn, step_up, step_dn;
  logic             wr_ctrl, wr_mode, wr_stat, wr_qctrl, wr_lower, wr_upper, wr_cnt;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL) && !lock_q;
  assign wr_mode  = wr_en_i && (addr_i == A_MODE);
  assign wr_stat  = wr_en_i && (addr_i == A_STAT);
  assign wr_qctrl = wr_en_i && (addr_i == A_QCTRL) && !lock_q;
  assign wr_lower = wr_en_i && (addr_i == A_LOWER) && ena_q;
  assign wr_upper = wr_en_i && (addr_i == A_UPPER) && ena_q;
  assign wr_cnt   = wr_en_i && (addr_i == A_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q    <= '0;
      ena_q   <= 1'b0;
      qen_q   <= 1'b0;
      lock_q  <= 1'b1;
      lower_q <= '0;
      upper_q <= '1;
    end else begin
      if (wr_ctrl)  ps_q  <= wdata_i[PS_W-1:0];
      if (wr_mode && !lock_q) ena_q <= wdata_i[MODE_ENA_BIT];
      if (wr_qctrl) qen_q <= wdata_i[QCTRL_EN_BIT];
      if (wr_stat && wdata_i[STAT_LOCK_BIT])      lock_q <= 1'b1;
      else if (wr_mode && wdata_i[MODE_OPEN_BIT]) lock_q <= 1'b0;
      if (wr_lower) lower_q <= wdata_i[CNT_W-1:0];
      if (wr_upper) upper_q <= wdata_i[CNT_W-1:0];
    end
  end

  qdec_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({phase_a_i, phase_b_i}),
    .q_o   (ab_s)
  );

  logic ph_up, ph_dn;
  qdec_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ab_i  (ab_s),
    .prev_o(ab_p),
    .up_o  (ph_up),
    .dn_o  (ph_dn)
  );

  assign ev_up = qen_q && ph_up;
  assign ev_dn = qen_q && ph_dn;

  qdec_presc #(.PS_W(PS_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wr_ctrl),
    .ps_i     (ps_q),
    .up_i     (ev_up),
    .dn_i     (ev_dn),
    .step_up_o(step_up),
    .step_dn_o(step_dn)
  );

  qdec_count #(.W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_cnt),
    .lower_i(lower_q),
    .upper_i(upper_q),
    .inc_i  (step_up),
    .dec_i  (step_dn),
    .cnt_o  (cnt)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[PS_W-1:0]     = ps_q;
      A_COUNT: rdata_o[CNT_W-1:0]    = cnt;
      A_UPPER: rdata_o[CNT_W-1:0]    = upper_q;
      A_LOWER: rdata_o[CNT_W-1:0]    = lower_q;
      A_MODE:  rdata_o[MODE_ENA_BIT] = ena_q;
      A_STAT:  rdata_o[STAT_LOCK_BIT] = lock_q;
      A_QCTRL: rdata_o[QCTRL_EN_BIT] = qen_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/qdec_timer_chk.sv
module qdec_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_en_i,
  input logic [qdec_pkg::REG_AW-1:0] addr_i,
  input logic                        wbit_lock,
  input logic                        qen,
  input logic                        ena,
  input logic                        lock,
  input logic [CNT_W-1:0]            cnt,
  input logic [CNT_W-1:0]            lower,
  input logic [CNT_W-1:0]            upper,
  input logic                        step_up,
  input logic [1:0]                  ab_s,
  input logic [1:0]                  ab_p
);
  import qdec_pkg::*;

  logic cnt_wr;
  assign cnt_wr = wr_en_i && (addr_i == A_COUNT);

  AST_DOUBLE_CHANGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qen && ((ab_s ^ ab_p) == 2'b11) && !cnt_wr) |=> (cnt == $past(cnt))); // R3
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!qen && !cnt_wr) |=> (cnt == $past(cnt))); // R4
  AST_COUNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (cnt == $past(lower))); // R5
  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_up && (cnt == upper) && !cnt_wr) |=> (cnt == $past(lower))); // R6
  AST_LOCKED_QCTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == A_QCTRL) && lock) |=> (qen == $past(qen))); // R8
  AST_LOCK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == A_STAT) && wbit_lock) |=> lock); // R8
  AST_BOUND_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == A_UPPER) && !ena) |=> (upper == $past(upper))); // R9
endmodule

bind qdec_timer qdec_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wbit_lock(wdata_i[qdec_pkg::STAT_LOCK_BIT]),
  .qen      (qen_q),
  .ena      (ena_q),
  .lock     (lock_q),
  .cnt      (cnt),
  .lower    (lower_q),
  .upper    (upper_q),
  .step_up  (step_up),
  .ab_s     (ab_s),
  .ab_p     (ab_p)
);

// File: tb/tb_qdec_timer.sv
`timescale 1ns/1ps
module tb_qdec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pa = 1'b0, pb = 1'b0;
  logic [1:0]  cur_ab = 2'b00;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  qdec_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .phase_a_i(pa), .phase_b_i(pb)
  );

  // {A,B}, expected count; decoder on, prescale 0, bounds 0..0xFFFF
  localparam logic [17:0] VEC [14] = '{
    {2'b10, 16'h0001}, {2'b11, 16'h0002}, {2'b01, 16'h0003}, {2'b00, 16'h0004},
    {2'b10, 16'h0005}, {2'b00, 16'h0004}, {2'b01, 16'h0003}, {2'b11, 16'h0002},
    {2'b10, 16'h0001}, {2'b00, 16'h0000}, {2'b01, 16'hFFFF}, {2'b00, 16'h0000},
    {2'b11, 16'h0000}, {2'b00, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic phase(input logic [1:0] ab);
    @(negedge clk);
    {pa, pb} = ab;
    cur_ab = ab;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [1:0] next_up(input logic [1:0] ab);
    case (ab)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd5, 32'h40, "R1 lock");
    rd(3'd1, 32'h0, "R1 count");
    rd(3'd3, 32'h0, "R1 lower");
    rd(3'd2, 32'hFFFF, "R1 upper");
    rd(3'd4, 32'h0, "R1 mode");
    rd(3'd0, 32'h0, "R1 prescale");
    rd(3'd6, 32'h0, "R1 qctrl");
    rd(3'd7, 32'h0, "R10 unmapped");
    // R8 writes ignored while locked
    wr(3'd6, 32'h1);
    rd(3'd6, 32'h0, "R8 locked qctrl");
    wr(3'd0, 32'h5);
    rd(3'd0, 32'h0, "R8 locked prescale");
    wr(3'd4, 32'h5);
    rd(3'd5, 32'h0, "R8 unlock");
    rd(3'd4, 32'h0, "R8 locked enable / R10 open bit");
    // R9 bounds ignored while mode enable is 0
    wr(3'd2, 32'h10);
    rd(3'd2, 32'hFFFF, "R9 upper gated");
    wr(3'd3, 32'h7);
    rd(3'd3, 32'h0, "R9 lower gated");
    wr(3'd4, 32'h1);
    rd(3'd4, 32'h1, "R8 mode enable accepted");
    wr(3'd6, 32'h1);
    rd(3'd6, 32'h1, "R8 qctrl accepted");
    // R2 R3 R6 table walk
    for (int i = 0; i < 14; i++) begin
      phase(VEC[i][17:16]);
      rd(3'd1, {16'h0, VEC[i][15:0]}, $sformatf("R2/R3/R6 vector %0d", i));
    end
    // R5 reload, R6 narrow bounds
    wr(3'd3, 32'h20);
    wr(3'd2, 32'h23);
    wr(3'd1, 32'hABCD);
    rd(3'd1, 32'h20, "R5 reload lower");
    phase(2'b10); phase(2'b11); phase(2'b01);
    rd(3'd1, 32'h23, "R2 count to upper");
    phase(2'b00);
    rd(3'd1, 32'h20, "R6 up wrap to lower");
    phase(2'b01);
    rd(3'd1, 32'h23, "R6 down wrap to upper");
    // R4 decoder disabled
    wr(3'd6, 32'h0);
    phase(2'b00); phase(2'b10);
    rd(3'd1, 32'h23, "R4 hold while disabled");
    wr(3'd6, 32'h1);
    // R7 prescale 2
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h2);
    rd(3'd0, 32'h2, "R7 prescale field");
    phase(next_up(cur_ab)); phase(next_up(cur_ab));
    rd(3'd1, 32'h20, "R7 partial events");
    wr(3'd0, 32'h2);
    for (int k = 0; k < 3; k++) phase(next_up(cur_ab));
    rd(3'd1, 32'h20, "R7 remainder cleared");
    phase(next_up(cur_ab));
    rd(3'd1, 32'h21, "R7 fourth event steps");
    // R8 relock
    wr(3'd5, 32'h40);
    rd(3'd5, 32'h40, "R8 relock");
    wr(3'd6, 32'h0);
    rd(3'd6, 32'h1, "R8 relocked qctrl");
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h2, "R8 relocked prescale");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule